// File: doc/BRIEF.md
# Sentry Jump Unit with Interrupt-Enable Control

This block commits control transfers made through capabilities and owns the processor's global interrupt-enable flag. A jump request presents a target capability made of a valid tag, a permission vector, an object type and an address. An unsealed executable target is installed as the new program-counter capability. A sealed target is accepted only when its object type is one of the sentry kinds. Jumping to a sentry unseals it on the fly, and the sentry's kind decides what happens to interrupt enable: it is kept, cleared or set.

When the jump also asks for a link, the block hands back a return capability. This capability is the caller's program-counter capability advanced past the jump and sealed as a return sentry. The return sentry's type records whether interrupts were on at the moment of the call, so a later jump through it restores that state. The interrupt flag can also be written directly, but only while the current program-counter capability carries the system-register permission. Any illegal request raises a one-cycle trap and leaves all state unchanged.

Top module: `sentry_jump_unit`

## Requirements
- R1: While reset is held low at a clock edge, the PC capability becomes tagged and unsealed (object type 0), with every permission bit set and address RESET_ADDR. Interrupt enable, trap and link-valid all become 0.
- R2: A jump to a tagged capability with object type 0 and the execute permission (bit 3) installs the target's tag, permissions and address as the PC capability one cycle later. Interrupt enable is unchanged.
- R3: A jump to a tagged, executable forward sentry installs the target with its object type cleared to 0. Object type 1 keeps interrupt enable, type 2 clears it and type 3 sets it, all in the same cycle the PC is committed.
- R4: A jump to a tagged, executable return sentry installs the target unsealed. Object type 4 clears interrupt enable and type 5 sets it.
- R5: A legal jump with the link request set raises link-valid for one cycle, in the cycle the new PC appears. The link capability has tag 1 and the caller's PC permissions. Its address is the caller's PC address plus LINK_STEP (default 4). Its object type is 5 if interrupts were enabled before the jump and 4 otherwise.
- R6: A jump to a target that is untagged, lacks execute permission, or has object type 6 or 7 raises trap for one cycle. PC, interrupt enable and the link output stay as they were, and link-valid stays 0.
- R7: A direct interrupt-enable write, made while the PC capability holds the system-register permission (bit 6), loads the written value one cycle later. It raises no trap.
- R8: A direct write made while the PC capability lacks bit 6 raises trap for one cycle and leaves interrupt enable unchanged.
- R9: When a jump and a direct write are requested in the same cycle, the jump alone takes effect. The write neither changes interrupt enable nor raises a trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| jmp_vld_i | input | 1 | Jump request this cycle |
| link_req_i | input | 1 | Jump also produces a return capability |
| tgt_tag_i | input | 1 | Target capability tag |
| tgt_perms_i | input | PERM_W | Target permission vector |
| tgt_otype_i | input | OTYPE_W | Target object type |
| tgt_addr_i | input | ADDR_W | Target address |
| csr_we_i | input | 1 | Direct interrupt-enable write request |
| csr_ie_i | input | 1 | Value for a direct write |
| pc_tag_o | output | 1 | PC capability tag |
| pc_perms_o | output | PERM_W | PC capability permissions |
| pc_otype_o | output | OTYPE_W | PC capability object type |
| pc_addr_o | output | ADDR_W | PC capability address |
| ie_o | output | 1 | Global interrupt enable |
| trap_o | output | 1 | Request of the previous cycle was refused |
| link_vld_o | output | 1 | Link capability produced by the previous cycle's jump |
| link_tag_o | output | 1 | Link capability tag |
| link_perms_o | output | PERM_W | Link capability permissions |
| link_otype_o | output | OTYPE_W | Link capability object type (return sentry) |
| link_addr_o | output | ADDR_W | Link capability address |

## Verification
The assertions assume that reset is held low for at least two edges before any request, so every history value they consult has already been reset. They also assume that the request inputs are stable around each clock edge. The bench drives all inputs on the falling edge and keeps them low during reset, so both conditions hold. The random phase draws every object type, including the two undefined codes, and toggles tag and execute permission. This exercises legal and refused jumps, linked and unlinked jumps, and collisions between a jump and a direct write, while the PC's system-register permission changes as targets are installed.

// File: rtl/sentry_pkg.sv
// Package: object-type codes shared by the sentry jump unit and its helpers.
// Assumes object types are at least 3 bits wide.
package sentry_pkg;
    localparam logic [2:0] OT_UNSEALED   = 3'd0;
    localparam logic [2:0] OT_FWD_KEEP   = 3'd1;
    localparam logic [2:0] OT_FWD_OFF    = 3'd2;
    localparam logic [2:0] OT_FWD_ON     = 3'd3;
    localparam logic [2:0] OT_RET_OFF    = 3'd4;
    localparam logic [2:0] OT_RET_ON     = 3'd5;

    // Effect of a committed jump on the interrupt-enable flag
    typedef enum logic [1:0] {
        IE_KEEP  = 2'd0,
        IE_CLEAR = 2'd1,
        IE_SET   = 2'd2
    } ie_act_e;
endpackage

// File: rtl/sentry_classify.sv
// Classifies a jump target: decides whether it may be installed as the PC
// and which interrupt-enable action its object type implies.
// Assumes the object-type field is at least 3 bits wide. Purely combinational.
module sentry_classify
    import sentry_pkg::*;
#(
    parameter int PERM_W   = 8,
    parameter int OTYPE_W  = 3,
    parameter int EXEC_BIT = 3
) (
    input  logic               tag_i,
    input  logic [PERM_W-1:0]  perms_i,
    input  logic [OTYPE_W-1:0] otype_i,
    output logic               legal_o,
    output ie_act_e            act_o
);
    localparam logic [OTYPE_W-1:0] K_UNS  = OTYPE_W'(OT_UNSEALED);
    localparam logic [OTYPE_W-1:0] K_FKP  = OTYPE_W'(OT_FWD_KEEP);
    localparam logic [OTYPE_W-1:0] K_FOF  = OTYPE_W'(OT_FWD_OFF);
    localparam logic [OTYPE_W-1:0] K_FON  = OTYPE_W'(OT_FWD_ON);
    localparam logic [OTYPE_W-1:0] K_ROF  = OTYPE_W'(OT_RET_OFF);
    localparam logic [OTYPE_W-1:0] K_RON  = OTYPE_W'(OT_RET_ON);

    logic type_ok;

    // Map the object type onto an interrupt action and a type-validity flag
    always_comb begin
        type_ok = 1'b1;
        act_o   = IE_KEEP;
        case (otype_i)
            K_UNS, K_FKP: act_o = IE_KEEP;
            K_FOF, K_ROF: act_o = IE_CLEAR;
            K_FON, K_RON: act_o = IE_SET;
            default: begin
                type_ok = 1'b0;
                act_o   = IE_KEEP;
            end
        endcase
    end

    // A target is usable only if tagged, executable and of a known type
    always_comb legal_o = tag_i & perms_i[EXEC_BIT] & type_ok;
endmodule

// File: rtl/ie_update.sv
// Computes the next interrupt-enable value from a committed jump or an
// authorised direct write. Assumes the caller has already resolved
// priority, so at most one of the two fire inputs is high.
module ie_update
    import sentry_pkg::*;
(
    input  logic    ie_q_i,
    input  logic    jump_fire_i,
    input  ie_act_e act_i,
    input  logic    csr_fire_i,
    input  logic    csr_val_i,
    output logic    ie_d_o
);
    // Select the interrupt-enable source for the next cycle
    always_comb begin
        ie_d_o = ie_q_i;
        if (jump_fire_i) begin
            case (act_i)
                IE_CLEAR: ie_d_o = 1'b0;
                IE_SET:   ie_d_o = 1'b1;
                default:  ie_d_o = ie_q_i;
            endcase
        end else if (csr_fire_i) begin
            ie_d_o = csr_val_i;
        end
    end
endmodule

// File: rtl/link_seal.sv
// Builds the return capability for a linked jump: the caller's PC moved
// past the jump, sealed as a return sentry whose type records the
// caller's interrupt state. Purely combinational.
module link_seal
    import sentry_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PERM_W    = 8,
    parameter int OTYPE_W   = 3,
    parameter int LINK_STEP = 4
) (
    input  logic [PERM_W-1:0]  pc_perms_i,
    input  logic [ADDR_W-1:0]  pc_addr_i,
    input  logic               ie_i,
    output logic               tag_o,
    output logic [PERM_W-1:0]  perms_o,
    output logic [OTYPE_W-1:0] otype_o,
    output logic [ADDR_W-1:0]  addr_o
);
    // Seal the return address with the type that restores the current state
    always_comb begin
        tag_o   = 1'b1;
        perms_o = pc_perms_i;
        otype_o = ie_i ? OTYPE_W'(OT_RET_ON) : OTYPE_W'(OT_RET_OFF);
        addr_o  = pc_addr_i + ADDR_W'(LINK_STEP);
    end
endmodule

// File: rtl/sentry_jump_unit.sv
// Sentry jump unit: holds the PC capability and the global interrupt-enable
// flag and commits jumps, linked jumps and direct interrupt writes.
// Assumes requests are single-cycle and that a jump outranks a direct write
// in the same cycle. All results appear one clock after the request.
module sentry_jump_unit
    import sentry_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          PERM_W     = 8,
    parameter int          OTYPE_W    = 3,
    parameter int          EXEC_BIT   = 3,
    parameter int          SYSREG_BIT = 6,
    parameter int          LINK_STEP  = 4,
    parameter int unsigned RESET_ADDR = 32'h8000_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               jmp_vld_i,
    input  logic               link_req_i,
    input  logic               tgt_tag_i,
    input  logic [PERM_W-1:0]  tgt_perms_i,
    input  logic [OTYPE_W-1:0] tgt_otype_i,
    input  logic [ADDR_W-1:0]  tgt_addr_i,
    input  logic               csr_we_i,
    input  logic               csr_ie_i,
    output logic               pc_tag_o,
    output logic [PERM_W-1:0]  pc_perms_o,
    output logic [OTYPE_W-1:0] pc_otype_o,
    output logic [ADDR_W-1:0]  pc_addr_o,
    output logic               ie_o,
    output logic               trap_o,
    output logic               link_vld_o,
    output logic               link_tag_o,
    output logic [PERM_W-1:0]  link_perms_o,
    output logic [OTYPE_W-1:0] link_otype_o,
    output logic [ADDR_W-1:0]  link_addr_o
);
    localparam logic [ADDR_W-1:0]  RST_PC  = ADDR_W'(RESET_ADDR);
    localparam logic [OTYPE_W-1:0] RET_ON  = OTYPE_W'(OT_RET_ON);
    localparam logic [OTYPE_W-1:0] RET_OFF = OTYPE_W'(OT_RET_OFF);

    logic               pc_tag_q;
    logic [PERM_W-1:0]  pc_perms_q;
    logic [OTYPE_W-1:0] pc_otype_q;
    logic [ADDR_W-1:0]  pc_addr_q;
    logic               ie_q, ie_d;
    logic               trap_q, lv_q;
    logic               l_tag_q;
    logic [PERM_W-1:0]  l_perms_q;
    logic [OTYPE_W-1:0] l_otype_q;
    logic [ADDR_W-1:0]  l_addr_q;

    logic               tgt_legal;
    ie_act_e            tgt_act;
    logic               jump_ok, jump_bad, csr_ok, csr_bad;
    logic               s_tag;
    logic [PERM_W-1:0]  s_perms;
    logic [OTYPE_W-1:0] s_otype;
    logic [ADDR_W-1:0]  s_addr;

    sentry_classify #(
        .PERM_W(PERM_W), .OTYPE_W(OTYPE_W), .EXEC_BIT(EXEC_BIT)
    ) u_cls (
        .tag_i(tgt_tag_i), .perms_i(tgt_perms_i), .otype_i(tgt_otype_i),
        .legal_o(tgt_legal), .act_o(tgt_act)
    );

    // Resolve request priority: a jump masks a direct write
    always_comb begin
        jump_ok  = jmp_vld_i & tgt_legal;
        jump_bad = jmp_vld_i & ~tgt_legal;
        csr_ok   = ~jmp_vld_i & csr_we_i & pc_perms_q[SYSREG_BIT];
        csr_bad  = ~jmp_vld_i & csr_we_i & ~pc_perms_q[SYSREG_BIT];
    end

    ie_update u_ie (
        .ie_q_i(ie_q), .jump_fire_i(jump_ok), .act_i(tgt_act),
        .csr_fire_i(csr_ok), .csr_val_i(csr_ie_i), .ie_d_o(ie_d)
    );

    link_seal #(
        .ADDR_W(ADDR_W), .PERM_W(PERM_W), .OTYPE_W(OTYPE_W), .LINK_STEP(LINK_STEP)
    ) u_link (
        .pc_perms_i(pc_perms_q), .pc_addr_i(pc_addr_q), .ie_i(ie_q),
        .tag_o(s_tag), .perms_o(s_perms), .otype_o(s_otype), .addr_o(s_addr)
    );

    // PC capability register: reset vector, or the unsealed legal target
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_tag_q   <= 1'b1;
            pc_perms_q <= '1;
            pc_otype_q <= '0;
            pc_addr_q  <= RST_PC;
        end else if (jump_ok) begin
            pc_tag_q   <= tgt_tag_i;
            pc_perms_q <= tgt_perms_i;
            pc_otype_q <= '0;
            pc_addr_q  <= tgt_addr_i;
        end
    end

    // Interrupt-enable flag, committed in the same edge as the PC
    always_ff @(posedge clk) begin
        if (!rst_n) ie_q <= 1'b0;
        else        ie_q <= ie_d;
    end

    // Single-cycle trap and link-valid pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_q <= 1'b0;
            lv_q   <= 1'b0;
        end else begin
            trap_q <= jump_bad | csr_bad;
            lv_q   <= jump_ok & link_req_i;
        end
    end

    // Link capability register, loaded only by a legal linked jump
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_tag_q   <= 1'b0;
            l_perms_q <= '0;
            l_otype_q <= '0;
            l_addr_q  <= '0;
        end else if (jump_ok && link_req_i) begin
            l_tag_q   <= s_tag;
            l_perms_q <= s_perms;
            l_otype_q <= s_otype;
            l_addr_q  <= s_addr;
        end
    end

    assign pc_tag_o     = pc_tag_q;
    assign pc_perms_o   = pc_perms_q;
    assign pc_otype_o   = pc_otype_q;
    assign pc_addr_o    = pc_addr_q;
    assign ie_o         = ie_q;
    assign trap_o       = trap_q;
    assign link_vld_o   = lv_q;
    assign link_tag_o   = l_tag_q;
    assign link_perms_o = l_perms_q;
    assign link_otype_o = l_otype_q;
    assign link_addr_o  = l_addr_q;

    // R6
    trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (pc_addr_q == $past(pc_addr_q) && ie_q == $past(ie_q)));

    // R6
    trap_nolink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_o && link_vld_o));

    // R5
    link_seal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_vld_o |-> (link_otype_o == ($past(ie_q) ? RET_ON : RET_OFF)
                        && link_addr_o == $past(pc_addr_q) + ADDR_W'(LINK_STEP)));

    // R2
    pc_install_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(jmp_vld_i) && !trap_o) |-> pc_addr_o == $past(tgt_addr_i));

    // R4
    ret_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(jmp_vld_i && tgt_tag_i && tgt_perms_i[EXEC_BIT] && tgt_otype_i == RET_ON)
        |-> ie_q);

    // R8
    ie_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_q != $past(ie_q)) |-> $past(jmp_vld_i || (csr_we_i && pc_perms_q[SYSREG_BIT])));
endmodule

// File: tb/sim_sentry_jump_unit.sv
module sim_sentry_jump_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        jmp_vld = 0, link_req = 0, t_tag = 0, csr_we = 0, csr_ie = 0;
    logic [7:0]  t_perms = 0;
    logic [2:0]  t_otype = 0;
    logic [31:0] t_addr = 0;
    logic        pc_tag, ie, trap, lv, l_tag;
    logic [7:0]  pc_perms, l_perms;
    logic [2:0]  pc_otype, l_otype;
    logic [31:0] pc_addr, l_addr;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference state
    logic        m_tag, m_ie, m_trap, m_lv;
    logic [7:0]  m_perms, m_lperms;
    logic [31:0] m_addr, m_laddr;
    logic [2:0]  m_lotype;
    string       pend;

    always #(CLK_PERIOD/2) clk = ~clk;

    sentry_jump_unit u0 (
        .clk(clk), .rst_n(rst_n), .jmp_vld_i(jmp_vld), .link_req_i(link_req),
        .tgt_tag_i(t_tag), .tgt_perms_i(t_perms), .tgt_otype_i(t_otype), .tgt_addr_i(t_addr),
        .csr_we_i(csr_we), .csr_ie_i(csr_ie),
        .pc_tag_o(pc_tag), .pc_perms_o(pc_perms), .pc_otype_o(pc_otype), .pc_addr_o(pc_addr),
        .ie_o(ie), .trap_o(trap), .link_vld_o(lv), .link_tag_o(l_tag),
        .link_perms_o(l_perms), .link_otype_o(l_otype), .link_addr_o(l_addr)
    );

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic compare_all(input string rq);
        chk(rq, "pc_tag", {31'd0, pc_tag}, {31'd0, m_tag});
        chk(rq, "pc_perms", {24'd0, pc_perms}, {24'd0, m_perms});
        chk(rq, "pc_otype", {29'd0, pc_otype}, 32'd0);
        chk(rq, "pc_addr", pc_addr, m_addr);
        chk(rq, "ie", {31'd0, ie}, {31'd0, m_ie});
        chk(rq, "trap", {31'd0, trap}, {31'd0, m_trap});
        chk(rq, "link_vld", {31'd0, lv}, {31'd0, m_lv});
        if (m_lv) begin
            chk(rq, "link_tag", {31'd0, l_tag}, 32'd1);
            chk(rq, "link_perms", {24'd0, l_perms}, {24'd0, m_lperms});
            chk(rq, "link_otype", {29'd0, l_otype}, {29'd0, m_lotype});
            chk(rq, "link_addr", l_addr, m_laddr);
        end
    endtask

    // One cycle: check the previous result, drive new inputs, advance the model
    task automatic step(input string rq, input logic j, input logic l, input logic t,
                        input logic [7:0] p, input logic [2:0] ot, input logic [31:0] a,
                        input logic cw, input logic cv);
        logic ok;
        @(negedge clk);
        compare_all(pend);
        jmp_vld = j; link_req = l; t_tag = t; t_perms = p; t_otype = ot;
        t_addr = a; csr_we = cw; csr_ie = cv;
        m_trap = 0;
        m_lv = 0;
        ok = t && p[3] && (ot < 3'd6);
        if (j) begin
            if (ok) begin
                if (l) begin
                    m_lv = 1;
                    m_lperms = m_perms;
                    m_laddr = m_addr + 32'd4;
                    m_lotype = m_ie ? 3'd5 : 3'd4;
                end
                m_tag = t; m_perms = p; m_addr = a;
                if (ot == 3'd2 || ot == 3'd4) m_ie = 0;
                else if (ot == 3'd3 || ot == 3'd5) m_ie = 1;
            end else begin
                m_trap = 1;
            end
        end else if (cw) begin
            if (m_perms[6]) m_ie = cv;
            else m_trap = 1;
        end
        pend = rq;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        m_tag = 1; m_perms = 8'hFF; m_addr = 32'h8000_0000; m_ie = 0;
        m_trap = 0; m_lv = 0; m_lperms = 0; m_laddr = 0; m_lotype = 0;
        pend = "R1";
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state checked by the first step
        step("R2", 1, 0, 1, 8'hCF, 3'd0, 32'h0000_1000, 0, 0); // unsealed jump
        step("R7", 0, 0, 0, 0, 0, 0, 1, 1);                   // authorised write enables
        step("R3", 1, 1, 1, 8'hCF, 3'd1, 32'h0000_2000, 0, 0); // inherit + link (R5)
        step("R3", 1, 0, 1, 8'hCF, 3'd2, 32'h0000_3000, 0, 0); // disable sentry
        step("R5", 1, 1, 1, 8'hCF, 3'd3, 32'h0000_4000, 0, 0); // enable sentry, link records off
        step("R5", 1, 1, 1, 8'hCF, 3'd0, 32'h0000_5000, 0, 0); // link records on
        step("R4", 1, 0, 1, 8'hCF, 3'd4, 32'h0000_6000, 0, 0); // return-off
        step("R4", 1, 0, 1, 8'hCF, 3'd5, 32'h0000_7000, 0, 0); // return-on
        step("R6", 1, 1, 0, 8'hFF, 3'd1, 32'h0000_8000, 0, 0); // untagged
        step("R6", 1, 1, 1, 8'hF7, 3'd0, 32'h0000_9000, 0, 0); // no execute
        step("R6", 1, 1, 1, 8'hFF, 3'd6, 32'h0000_A000, 0, 0); // type 6
        step("R6", 1, 0, 1, 8'hFF, 3'd7, 32'h0000_B000, 0, 0); // type 7
        step("R2", 1, 0, 1, 8'h0F, 3'd0, 32'h0000_C000, 0, 0); // PC without sysreg
        step("R8", 0, 0, 0, 0, 0, 0, 1, 0);                   // refused write
        step("R9", 1, 0, 1, 8'h4F, 3'd1, 32'h0000_D000, 1, 0); // jump wins over write
        step("R7", 0, 0, 0, 0, 0, 0, 1, 0);                   // authorised write disables
        step("R9", 1, 0, 1, 8'h4F, 3'd0, 32'h0000_E000, 1, 1); // write ignored, ie stays 0
        for (int i = 0; i < 400; i++) begin
            logic [7:0] p;
            p = 8'($urandom);
            p[3] = ($urandom % 6) != 0;
            step("R2", ($urandom % 4) != 0, 1'($urandom), ($urandom % 8) != 0, p,
                 3'($urandom), $urandom, 1'($urandom), 1'($urandom));
        end
        step("R2", 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        compare_all(pend);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule